// File: doc/BRIEF.md
# Program Counter and Stack Pointer Register Bank

This block keeps two 20-bit address pointers for a small CPU that moves 16-bit data words. The first is the program counter. The second is the system stack pointer. Every cycle, the instruction sequencer can move the program counter forward by one, two or three words. The push/pop logic can move the stack pointer up or down by one. Each pointer wraps around modulo 2^20.

The ALU has no direct path to either pointer. Software reaches them only through a 16-entry special-register window that sits at bus addresses 0x00010 to 0x0001F. A bus access counts only when chip select is high. Separate write and read enables say which way the access goes. Each pointer appears in the window as two 16-bit words:

- The low word carries bits 15:0 of the pointer.
- The high word carries bits 19:16, padded with zeros up to 16 bits.

A bus write always wins over a step of the same pointer in the same cycle. The four top program-counter bits are also driven out for the local (same 64K-word page) addressing mode.

Top module: `spr_pointer_bank`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, both pointers become 0. The reset is synchronous.
- R2: `pc_step` moves the program counter forward, modulo 2^20. The encodings are 00 hold, 01 add 1, 10 add 2 and 11 add 3.
- R3: The stack pointer changes as follows, modulo 2^20:
  - `sp_up` alone adds 1.
  - `sp_dn` alone subtracts 1.
  - Both asserted, or neither asserted, leaves it unchanged.
- R4: `bus_hit` is high exactly when `bus_cs` is high and `bus_addr` lies within 0x00010 to 0x0001F.
- R5: The window decodes by offset (`bus_addr` minus 0x10), as listed below. While `bus_cs`, `bus_re` and `bus_hit` are all high, `bus_rdata` shows the addressed word in the same cycle. At all other times it is 0.
  - Offset 0x0 is program counter bits 15:0.
  - Offset 0x1 is program counter bits 19:16, zero-extended.
  - Offset 0x2 is stack pointer bits 15:0.
  - Offset 0x3 is stack pointer bits 19:16, zero-extended.
  - Offsets 0x4 to 0xF read as 0.
- R6: A write happens when `bus_cs`, `bus_we` and `bus_hit` are all high.
  - At a low-word offset, the write replaces pointer bits 15:0 with `bus_wdata` and keeps bits 19:16.
  - At a high-word offset, the write loads bits 19:16 from `bus_wdata[3:0]`, keeps bits 15:0 and ignores `bus_wdata[15:4]`.
- R7: When a pointer is written, any step requested for it in the same cycle is dropped. The other pointer still steps normally.
- R8: The following writes change neither pointer:
  - writes with `bus_cs` low;
  - writes outside the window;
  - writes to offsets 0x4 to 0xF.
- R9: `pc_page` always equals program counter bits 19:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 20 | Word address of the bus access |
| bus_cs | input | 1 | Chip select that qualifies the access |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data; 0 when no window read is active |
| bus_hit | output | 1 | The access falls inside the special-register window |
| pc_step | input | 2 | Program counter advance: 0, 1, 2 or 3 words |
| sp_up | input | 1 | Stack pointer increment |
| sp_dn | input | 1 | Stack pointer decrement |
| pc_value | output | 20 | Current program counter |
| sp_value | output | 20 | Current stack pointer |
| pc_page | output | 4 | Program counter bits 19:16 |

## Verification
The properties assume the following about the inputs:
- A single access addresses one offset, so at most one pointer word is written per cycle.
- `pc_step`, `sp_up` and `sp_dn` never carry unknown values while reset is released.

The stimulus keeps to these assumptions. It drives every input to a defined value on each falling edge and holds it until the next one. A bus cycle carries a single address. The bench also drives simultaneous up and down requests, so the hold case of R3 is exercised rather than excluded.

// File: rtl/spr_pkg.sv
// Package: shared widths and window offsets for the pointer bank.
// Assumes the pointer is wider than a data word and narrower than two.
package spr_pkg;
    localparam int ADDR_W  = 20;
    localparam int DATA_W  = 16;
    localparam int PTR_W   = 20;
    localparam int STEP_W  = 2;
    localparam int WIN_LG  = 4;
    localparam logic [ADDR_W-1:0] WIN_BASE = 20'h00010;
    localparam int HI_W    = PTR_W - DATA_W;

    typedef enum logic [WIN_LG-1:0] {
        OFS_PC_LO = 4'h0,
        OFS_PC_HI = 4'h1,
        OFS_SP_LO = 4'h2,
        OFS_SP_HI = 4'h3
    } spr_ofs_e;

    typedef struct packed {
        logic lo;
        logic hi;
    } word_wr_t;
endpackage

// File: rtl/spr_window_decode.sv
// Window decoder: qualifies a bus access against the special-register
// window and turns it into per-word write strobes and a read enable.
// Assumes one address per cycle, so at most one strobe is active.
module spr_window_decode
    import spr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LG = WIN_LG,
    parameter logic [AW-1:0] BASE = WIN_BASE
) (
    input  logic [AW-1:0] addr,
    input  logic          cs,
    input  logic          we,
    input  logic          re,
    output logic          hit,
    output logic          rd_en,
    output logic [LG-1:0] offset,
    output word_wr_t      pc_wr,
    output word_wr_t      sp_wr
);
    logic in_win;

    // Compare the upper address bits with the window base.
    always_comb begin
        in_win = (addr[AW-1:LG] == BASE[AW-1:LG]);
        hit    = cs && in_win;
        rd_en  = hit && re;
        offset = addr[LG-1:0];
    end

    // Turn a qualified write into one strobe per pointer word.
    always_comb begin
        pc_wr.lo = hit && we && (offset == LG'(OFS_PC_LO));
        pc_wr.hi = hit && we && (offset == LG'(OFS_PC_HI));
        sp_wr.lo = hit && we && (offset == LG'(OFS_SP_LO));
        sp_wr.hi = hit && we && (offset == LG'(OFS_SP_HI));
    end
endmodule

// File: rtl/spr_pointer_reg.sv
// Pointer register: a 20-bit pointer that can be loaded one word at a
// time and stepped otherwise. The STACK_MODE parameter selects the
// stepping variant:
//   0 - forward advance by 0..3 (program counter)
//   1 - up/down by one (stack pointer)
// Assumes lo and hi strobes are never both high.
module spr_pointer_reg
    import spr_pkg::*;
#(
    parameter int PW = PTR_W,
    parameter int DW = DATA_W,
    parameter int SW = STEP_W,
    parameter bit STACK_MODE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  word_wr_t      wr,
    input  logic [DW-1:0] wdata,
    input  logic [SW-1:0] step,
    input  logic          up,
    input  logic          dn,
    output logic [PW-1:0] q
);
    localparam int HW = PW - DW;

    logic [PW-1:0] stepped;

    generate
        if (STACK_MODE) begin : g_stack
            // Plus or minus one; conflicting or absent requests hold.
            always_comb begin
                if (up && !dn)
                    stepped = q + PW'(1);
                else if (dn && !up)
                    stepped = q - PW'(1);
                else
                    stepped = q;
            end
            logic unused_step;
            assign unused_step = ^step;
        end else begin : g_fwd
            // Forward advance by the requested word count.
            always_comb stepped = q + PW'(step);
            logic unused_updn;
            assign unused_updn = up ^ dn;
        end
    endgenerate

    // Reset, then word loads, then stepping, in that priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr.lo)
            q[DW-1:0] <= wdata;
        else if (wr.hi)
            q[PW-1:DW] <= wdata[HW-1:0];
        else
            q <= stepped;
    end
endmodule

// File: rtl/spr_read_mux.sv
// Read multiplexer: picks the addressed pointer word and drives zero
// when no read is active or the offset is unassigned.
module spr_read_mux
    import spr_pkg::*;
#(
    parameter int PW = PTR_W,
    parameter int DW = DATA_W,
    parameter int LG = WIN_LG
) (
    input  logic          rd_en,
    input  logic [LG-1:0] offset,
    input  logic [PW-1:0] pc,
    input  logic [PW-1:0] sp,
    output logic [DW-1:0] rdata
);
    localparam int HW = PW - DW;

    // Select the word that the offset names.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (offset)
                LG'(OFS_PC_LO): rdata = pc[DW-1:0];
                LG'(OFS_PC_HI): rdata = {{(DW-HW){1'b0}}, pc[PW-1:DW]};
                LG'(OFS_SP_LO): rdata = sp[DW-1:0];
                LG'(OFS_SP_HI): rdata = {{(DW-HW){1'b0}}, sp[PW-1:DW]};
                default:        rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/spr_pointer_bank.sv
// Top: the program counter and the stack pointer, both reached through a
// memory-mapped special-register window.
// Assumes bus inputs are stable around the rising edge.
module spr_pointer_bank
    import spr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_hit,
    input  logic [STEP_W-1:0] pc_step,
    input  logic              sp_up,
    input  logic              sp_dn,
    output logic [PTR_W-1:0]  pc_value,
    output logic [PTR_W-1:0]  sp_value,
    output logic [HI_W-1:0]   pc_page
);
    logic              rd_en;
    logic [WIN_LG-1:0] offset;
    word_wr_t          pc_wr;
    word_wr_t          sp_wr;
    logic              pc_wr_any;
    logic              sp_wr_any;

    spr_window_decode i_dec (
        .addr   (bus_addr),
        .cs     (bus_cs),
        .we     (bus_we),
        .re     (bus_re),
        .hit    (bus_hit),
        .rd_en  (rd_en),
        .offset (offset),
        .pc_wr  (pc_wr),
        .sp_wr  (sp_wr)
    );

    spr_pointer_reg #(.STACK_MODE(1'b0)) i_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (pc_wr),
        .wdata (bus_wdata),
        .step  (pc_step),
        .up    (1'b0),
        .dn    (1'b0),
        .q     (pc_value)
    );

    spr_pointer_reg #(.STACK_MODE(1'b1)) i_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (sp_wr),
        .wdata (bus_wdata),
        .step  ('0),
        .up    (sp_up),
        .dn    (sp_dn),
        .q     (sp_value)
    );

    spr_read_mux i_rmux (
        .rd_en  (rd_en),
        .offset (offset),
        .pc     (pc_value),
        .sp     (sp_value),
        .rdata  (bus_rdata)
    );

    // Export the page bits; collapse strobes for the checker.
    always_comb begin
        pc_page   = pc_value[PTR_W-1:DATA_W];
        pc_wr_any = pc_wr.lo || pc_wr.hi;
        sp_wr_any = sp_wr.lo || sp_wr.hi;
    end
endmodule

// File: rtl/spr_pointer_bank_chk.sv
// Checker: temporal properties of the pointer bank, bound to the top.
module spr_pointer_bank_chk
    import spr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cs,
    input logic              bus_re,
    input logic              bus_hit,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [STEP_W-1:0] pc_step,
    input logic              sp_up,
    input logic              sp_dn,
    input logic [PTR_W-1:0]  pc_value,
    input logic [PTR_W-1:0]  sp_value,
    input logic              pc_wr_lo,
    input logic              pc_wr_any,
    input logic              sp_wr_any
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (pc_value == '0 && sp_value == '0));

    a_r2_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_wr_any |=> pc_value == $past(pc_value) + PTR_W'($past(pc_step)));

    a_r3_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sp_wr_any && sp_up == sp_dn) |=> $stable(sp_value));

    a_r3_sp_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!sp_wr_any && sp_up && !sp_dn) |=> sp_value == $past(sp_value) + PTR_W'(1));

    a_r4_hit_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hit |-> bus_cs);

    a_r5_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && bus_re && bus_hit) |-> bus_rdata == '0);

    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_lo |=> pc_value[DATA_W-1:0] == $past(bus_wdata));
endmodule

bind spr_pointer_bank spr_pointer_bank_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cs    (bus_cs),
    .bus_re    (bus_re),
    .bus_hit   (bus_hit),
    .bus_rdata (bus_rdata),
    .bus_wdata (bus_wdata),
    .pc_step   (pc_step),
    .sp_up     (sp_up),
    .sp_dn     (sp_dn),
    .pc_value  (pc_value),
    .sp_value  (sp_value),
    .pc_wr_lo  (pc_wr.lo),
    .pc_wr_any (pc_wr_any),
    .sp_wr_any (sp_wr_any)
);

// File: tb/test_spr_pointer_bank.sv
`timescale 1ns/1ps
module test_spr_pointer_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        bus_cs = 1'b0, bus_we = 1'b0, bus_re = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_hit;
    logic [1:0]  pc_step = '0;
    logic        sp_up = 1'b0, sp_dn = 1'b0;
    logic [19:0] pc_value, sp_value;
    logic [3:0]  pc_page;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int mpc = 0;
    int msp = 0;
    int seed = 32'h1234_5678;

    spr_pointer_bank i_spr_pointer_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_cs(bus_cs),
        .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_hit(bus_hit), .pc_step(pc_step),
        .sp_up(sp_up), .sp_dn(sp_dn), .pc_value(pc_value),
        .sp_value(sp_value), .pc_page(pc_page)
    );

    always #4 clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h00FF_FFFF;
    endfunction

    // Apply one cycle of stimulus, compare outputs with the model, then
    // advance the model across the rising edge.
    task automatic cyc(string req, int addr, bit cs, bit we, bit re, int wd,
                       int step, bit up, bit dn, bit rn);
        int off;
        bit hitm;
        int exp_rd;
        @(negedge clk);
        rst_n = rn; bus_addr = 20'(addr); bus_cs = cs; bus_we = we;
        bus_re = re; bus_wdata = 16'(wd); pc_step = 2'(step);
        sp_up = up; sp_dn = dn;
        #1;
        hitm = cs && addr >= 'h10 && addr <= 'h1F;
        off = addr - 'h10;
        exp_rd = 0;
        if (hitm && re) begin
            case (off)
                0: exp_rd = mpc & 'hFFFF;
                1: exp_rd = mpc >> 16;
                2: exp_rd = msp & 'hFFFF;
                3: exp_rd = msp >> 16;
                default: exp_rd = 0;
            endcase
        end
        check(req, "pc_value", int'(pc_value), mpc);
        check(req, "sp_value", int'(sp_value), msp);
        check("R9", "pc_page", int'(pc_page), mpc >> 16);
        check("R4", "bus_hit", int'(bus_hit), int'(hitm));
        check("R5", "bus_rdata", int'(bus_rdata), exp_rd);
        @(posedge clk);
        if (!rn) begin
            mpc = 0; msp = 0;
        end else begin
            if (hitm && we && off == 0)      mpc = (mpc & 'hF0000) | (wd & 'hFFFF);
            else if (hitm && we && off == 1) mpc = (mpc & 'hFFFF) | ((wd & 'hF) << 16);
            else                             mpc = (mpc + step) % 'h100000;
            if (hitm && we && off == 2)      msp = (msp & 'hF0000) | (wd & 'hFFFF);
            else if (hitm && we && off == 3) msp = (msp & 'hFFFF) | ((wd & 'hF) << 16);
            else if (up && !dn)              msp = (msp + 1) % 'h100000;
            else if (dn && !up)              msp = (msp + 'hFFFFF) % 'h100000;
        end
    endtask

    initial begin
        // R1: reset, then the pointers read zero
        cyc("R1", 0, 0, 0, 0, 0, 3, 1, 0, 0);
        cyc("R1", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R2: each step encoding
        for (int i = 0; i < 8; i++) cyc("R2", 0, 0, 0, 0, 0, i % 4, 0, 0, 1);
        // R3: up, down, both, neither
        cyc("R3", 0, 0, 0, 0, 0, 0, 1, 0, 1);
        cyc("R3", 0, 0, 0, 0, 0, 0, 1, 0, 1);
        cyc("R3", 0, 0, 0, 0, 0, 0, 0, 1, 1);
        cyc("R3", 0, 0, 0, 0, 0, 0, 1, 1, 1);
        cyc("R3", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R6: word writes, high word ignores upper data bits
        cyc("R6", 'h10, 1, 1, 0, 'hBEEF, 0, 0, 0, 1);
        cyc("R6", 'h11, 1, 1, 0, 'hFFF5, 0, 0, 0, 1);
        cyc("R6", 'h12, 1, 1, 0, 'h1234, 0, 0, 0, 1);
        cyc("R6", 'h13, 1, 1, 0, 'h00A9, 0, 0, 0, 1);
        // R5: read every window offset
        for (int a = 'h10; a <= 'h1F; a++) cyc("R5", a, 1, 0, 1, 0, 0, 0, 0, 1);
        cyc("R5", 'h10, 0, 0, 1, 0, 0, 0, 0, 1);
        cyc("R5", 'h20, 1, 0, 1, 0, 0, 0, 0, 1);
        // R2 wrap: load FFFFF then advance 3
        cyc("R2", 'h10, 1, 1, 0, 'hFFFF, 0, 0, 0, 1);
        cyc("R2", 'h11, 1, 1, 0, 'h000F, 0, 0, 0, 1);
        cyc("R2", 0, 0, 0, 0, 0, 3, 0, 0, 1);
        cyc("R2", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R3 wrap: load zero then decrement
        cyc("R3", 'h12, 1, 1, 0, 0, 0, 0, 0, 1);
        cyc("R3", 'h13, 1, 1, 0, 0, 0, 0, 0, 1);
        cyc("R3", 0, 0, 0, 0, 0, 0, 0, 1, 1);
        cyc("R3", 0, 0, 0, 0, 0, 0, 1, 0, 1);
        // R7: write and step collide; other pointer still moves
        cyc("R7", 'h10, 1, 1, 0, 'h4444, 3, 1, 0, 1);
        cyc("R7", 'h12, 1, 1, 0, 'h7777, 2, 0, 1, 1);
        cyc("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R8: writes that must not land
        cyc("R8", 'h10, 0, 1, 0, 'h1111, 0, 0, 0, 1);
        cyc("R8", 'h00, 1, 1, 0, 'h2222, 0, 0, 0, 1);
        cyc("R8", 'h30, 1, 1, 0, 'h3333, 0, 0, 0, 1);
        cyc("R8", 'h14, 1, 1, 0, 'h5555, 0, 0, 0, 1);
        cyc("R8", 'h1F, 1, 1, 0, 'h6666, 0, 0, 0, 1);
        cyc("R8", 'h10, 1, 0, 1, 0, 0, 0, 0, 1);
        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            int r = rnd();
            int a = ((r & 3) == 0) ? (r >> 4) & 'hFFFFF : 'h10 + ((r >> 4) & 'hF);
            cyc("R2", a, r[8], r[9], r[10], rnd(), r[12:11], r[13], r[14],
                (r[23:18] != 0));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule